// File: doc/BRIEF.md
# Strobed Input Handshake Channel

This block is one 8-bit receive channel of a parallel port running in strobed-input mode. A peripheral drives a byte and pulls an active-low strobe. The channel captures the byte into a holding register and raises a buffer-full flag. When the strobe has returned high, the channel raises an interrupt request, provided its interrupt enable is set. The CPU then reads the held byte with an active-low read pulse. The start of that pulse withdraws the interrupt request, and its end empties the buffer.

The peripheral data, the strobe and the CPU read pulse are asynchronous to the system clock. Each passes through a two-flop synchroniser, and all edge detection works on the synchronised copies. The interrupt enable is written by the port-C bit set/reset command, which is synchronous to the clock. The command carries a bit index and a value. The enable listens to bit 4 when the instance is configured as channel A, and to bit 2 when it is configured as channel B. The flags are also presented on the channel's port-C positions, together with an output-enable mask that marks which of those pins this channel drives.

Top module: `strobed_in_chan`

## Requirements
- R1: While the synchronised strobe is low, the holding register follows the synchronised peripheral data on every clock. While the strobe is high, the holding register keeps its value.
- R2: A low level on the synchronised strobe sets the buffer-full flag on the next clock, whatever its previous value.
- R3: The rising edge of the synchronised read clears the buffer-full flag. If the strobe is low in the same cycle, the strobe wins and buffer-full stays 1.
- R4: The interrupt request rises one clock after the cycle in which the strobe is high, buffer-full is 1, the enable is 1 and the read is idle (high and not rising). The request is never 1 while buffer-full is 0.
- R5: The falling edge of the synchronised read clears the interrupt request. The request stays 0 for the rest of the read pulse, and buffer-full stays unchanged until the read ends.
- R6: While the interrupt enable is 0, the interrupt request is 0 from the next clock on. Buffer-full and data capture work as usual.
- R7: A set/reset command with bit index 4 (channel A) or 2 (channel B) loads the command value into the interrupt enable on the next clock. Any other bit index leaves the enable unchanged.
- R8: The port-C outputs place the channel-A flags as interrupt on bit 3 and buffer-full on bit 5, with output-enable mask 8'h28 (bit 4, the strobe, is an input). The channel-B flags are placed as interrupt on bit 0 and buffer-full on bit 1, with mask 8'h03 (bit 2, the strobe, is an input). All other bits of both outputs are 0.
- R9: With the default two synchroniser stages, a level change on the strobe pin reaches buffer-full on the third rising clock edge after the change.
- R10: A second strobe while buffer-full is already 1 overwrites the held byte with the new data. Buffer-full stays 1, and no other output signals the overrun.
- R11: After reset, buffer-full, interrupt request and interrupt enable are 0, and the held byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_data | input | DATA_W | Peripheral data, asynchronous |
| pin_stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| cpu_rd_n | input | 1 | CPU read pulse, active low, asynchronous |
| bsr_wr | input | 1 | One-cycle port-C bit set/reset command |
| bsr_bit | input | 3 | Port-C bit index of the command |
| bsr_val | input | 1 | Value written by the command |
| rd_data | output | DATA_W | Held byte presented to the CPU |
| ibf | output | 1 | Buffer-full flag |
| intr | output | 1 | Interrupt request |
| inte | output | 1 | Interrupt enable |
| pc_out | output | 8 | Channel flags at their port-C positions |
| pc_oe | output | 8 | Port-C pins driven by this channel |

## Verification
Two functions can fall on the same clock: a new strobe that sets buffer-full, and the end of a CPU read that clears it. The bench provokes this by releasing the read and lowering the strobe at the same clock edge. Both signals then pass through synchronisers of equal depth, so they arrive in the same cycle. The result is judged at the ports: buffer-full must stay 1, the held byte must be the new data, and after the strobe is released the interrupt must follow the enable. The clash between the start of a read and the interrupt set condition is covered by random sequences, which compare the request against a bench model after every step.

// File: rtl/sih_pkg.sv
package sih_pkg;

  typedef enum logic {
    SIH_CHAN_A = 1'b0,
    SIH_CHAN_B = 1'b1
  } sih_chan_e;

  // Port-C placement of one channel's signals
  typedef struct packed {
    logic [2:0] intr_pos;
    logic [2:0] ibf_pos;
    logic [2:0] inte_pos;
  } sih_pcmap_t;

  function automatic sih_pcmap_t sih_map(sih_chan_e chan);
    sih_pcmap_t m;
    if (chan == SIH_CHAN_A) begin
      m.intr_pos = 3'd3;
      m.ibf_pos  = 3'd5;
      m.inte_pos = 3'd4;
    end else begin
      m.intr_pos = 3'd0;
      m.ibf_pos  = 3'd1;
      m.inte_pos = 3'd2;
    end
    return m;
  endfunction

  // Strobe level sets, read rising edge clears, strobe wins
  function automatic logic sih_ibf_next(logic ibf_q, logic stb_lo, logic rd_rise);
    return stb_lo | (ibf_q & ~rd_rise);
  endfunction

  // Request is sticky until read falls or enable drops
  function automatic logic sih_intr_next(logic intr_q, logic ibf_q, logic stb_hi,
                                         logic rd_hi, logic rd_rise, logic rd_fall,
                                         logic inte_q);
    logic set_c;
    set_c = stb_hi & ibf_q & rd_hi & ~rd_rise;
    return inte_q & ~rd_fall & (intr_q | set_c);
  endfunction

  function automatic logic sih_inte_next(logic inte_q, logic wr, logic [2:0] bit_idx,
                                         logic val, logic [2:0] own_pos);
    return (wr && (bit_idx == own_pos)) ? val : inte_q;
  endfunction

endpackage

// File: rtl/sih_sync.sv
module sih_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] src [STAGES];
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign src[g] = d;
    end else begin : g_next
      assign src[g] = stg[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= src[g];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sih_edge.sv
module sih_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/sih_flags.sv
module sih_flags
  import sih_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [2:0]  INTE_POS = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              rd_s,
  input  logic              rd_rise,
  input  logic              rd_fall,
  input  logic              bsr_wr,
  input  logic [2:0]        bsr_bit,
  input  logic              bsr_val,
  output logic [DATA_W-1:0] hold_q,
  output logic              ibf_q,
  output logic              intr_q,
  output logic              inte_q
);

  logic capture;
  logic ibf_d, intr_d, inte_d;

  assign capture = ~stb_s;
  assign ibf_d   = sih_ibf_next(ibf_q, capture, rd_rise);
  assign intr_d  = sih_intr_next(intr_q, ibf_q, stb_s, rd_s, rd_rise, rd_fall, inte_q);
  assign inte_d  = sih_inte_next(inte_q, bsr_wr, bsr_bit, bsr_val, INTE_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ibf_q  <= 1'b0;
      intr_q <= 1'b0;
      inte_q <= 1'b0;
    end else begin
      if (capture) hold_q <= data_s;
      ibf_q  <= ibf_d;
      intr_q <= intr_d;
      inte_q <= inte_d;
    end
  end

endmodule

// File: rtl/sih_pcmap.sv
module sih_pcmap
  import sih_pkg::*;
#(
  parameter sih_chan_e CHAN = SIH_CHAN_A
) (
  input  logic       ibf,
  input  logic       intr,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  localparam sih_pcmap_t MAP = sih_map(CHAN);

  for (genvar i = 0; i < 8; i++) begin : g_pin
    localparam bit IS_INTR = (3'(i) == MAP.intr_pos);
    localparam bit IS_IBF  = (3'(i) == MAP.ibf_pos);
    if (IS_INTR) begin : g_intr
      assign pc_out[i] = intr;
      assign pc_oe[i]  = 1'b1;
    end else if (IS_IBF) begin : g_ibf
      assign pc_out[i] = ibf;
      assign pc_oe[i]  = 1'b1;
    end else begin : g_none
      assign pc_out[i] = 1'b0;
      assign pc_oe[i]  = 1'b0;
    end
  end

endmodule

// File: rtl/strobed_in_chan.sv
module strobed_in_chan
  import sih_pkg::*;
#(
  parameter int        DATA_W      = 8,
  parameter int        SYNC_STAGES = 2,
  parameter sih_chan_e CHAN        = SIH_CHAN_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_stb_n,
  input  logic              cpu_rd_n,
  input  logic              bsr_wr,
  input  logic [2:0]        bsr_bit,
  input  logic              bsr_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              ibf,
  output logic              intr,
  output logic              inte,
  output logic [7:0]        pc_out,
  output logic [7:0]        pc_oe
);

  localparam sih_pcmap_t MAP      = sih_map(CHAN);
  localparam logic [2:0] INTE_POS = MAP.inte_pos;
  localparam int         BUN_W    = DATA_W + 1;
  localparam logic [BUN_W-1:0] BUN_RST = {1'b1, {DATA_W{1'b0}}};

  // Named internal events, also observed by the bound checker
  logic [BUN_W-1:0]  bun_s;
  logic              stb_s;
  logic [DATA_W-1:0] data_s;
  logic              rd_s;
  logic              rd_rise;
  logic              rd_fall;

  // Strobe and data share one synchroniser so they stay aligned
  sih_sync #(.W(BUN_W), .STAGES(SYNC_STAGES), .RST_VAL(BUN_RST)) u_sync_in (
    .clk(clk), .rst_n(rst_n), .d({pin_stb_n, pin_data}), .q(bun_s)
  );

  assign stb_s  = bun_s[BUN_W-1];
  assign data_s = bun_s[DATA_W-1:0];

  sih_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
    .clk(clk), .rst_n(rst_n), .d(cpu_rd_n), .q(rd_s)
  );

  sih_edge #(.IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .lvl(rd_s), .rise(rd_rise), .fall(rd_fall)
  );

  sih_flags #(.DATA_W(DATA_W), .INTE_POS(INTE_POS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .stb_s(stb_s), .data_s(data_s),
    .rd_s(rd_s), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
    .hold_q(rd_data), .ibf_q(ibf), .intr_q(intr), .inte_q(inte)
  );

  sih_pcmap #(.CHAN(CHAN)) u_pcmap (
    .ibf(ibf), .intr(intr), .pc_out(pc_out), .pc_oe(pc_oe)
  );

endmodule

// File: rtl/strobed_in_chan_chk.sv
module strobed_in_chan_chk #(
  parameter int         DATA_W   = 8,
  parameter logic [2:0] INTE_POS = 3'd4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_s,
  input logic              rd_s,
  input logic              rd_rise,
  input logic              rd_fall,
  input logic              bsr_wr,
  input logic [2:0]        bsr_bit,
  input logic              bsr_val,
  input logic [DATA_W-1:0] rd_data,
  input logic              ibf,
  input logic              intr,
  input logic              inte
);

  AST_HOLD_WHILE_STB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> $stable(rd_data)); // R1

  AST_IBF_SET_BY_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s |=> ibf); // R2

  AST_IBF_CLR_BY_RD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && stb_s) |=> !ibf); // R3

  AST_INTR_IMPLIES_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ibf); // R4

  AST_INTR_CLR_BY_RD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> !intr); // R5

  AST_INTR_LOW_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> !intr); // R5

  AST_INTE_GATES_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    !inte |=> !intr); // R6

  AST_INTE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_wr && bsr_bit == INTE_POS) |=> (inte == $past(bsr_val))); // R7

  AST_INTE_OTHER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_wr && bsr_bit != INTE_POS) |=> $stable(inte)); // R7

endmodule

bind strobed_in_chan strobed_in_chan_chk #(.DATA_W(DATA_W), .INTE_POS(INTE_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .rd_s(rd_s), .rd_rise(rd_rise),
  .rd_fall(rd_fall), .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
  .rd_data(rd_data), .ibf(ibf), .intr(intr), .inte(inte)
);

// File: tb/strobed_in_chan_tb_top.sv
module strobed_in_chan_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_data = 8'h00;
  logic       pin_stb_n = 1'b1;
  logic       cpu_rd_n = 1'b1;
  logic       bsr_wr = 1'b0;
  logic [2:0] bsr_bit = 3'd0;
  logic       bsr_val = 1'b0;

  logic [7:0] a_data, b_data, a_pco, a_pcoe, b_pco, b_pcoe;
  logic       a_ibf, a_intr, a_inte, b_ibf, b_intr, b_inte;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Model state: index 0 = channel A, 1 = channel B
  logic [7:0] m_data = 8'h00;
  logic       m_ibf  = 1'b0;
  logic       m_inte [2] = '{1'b0, 1'b0};
  logic       m_intr [2] = '{1'b0, 1'b0};

  always #4 clk = ~clk;

  strobed_in_chan dut_i (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_stb_n(pin_stb_n),
    .cpu_rd_n(cpu_rd_n), .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
    .rd_data(a_data), .ibf(a_ibf), .intr(a_intr), .inte(a_inte),
    .pc_out(a_pco), .pc_oe(a_pcoe)
  );

  strobed_in_chan #(.CHAN(sih_pkg::SIH_CHAN_B)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_stb_n(pin_stb_n),
    .cpu_rd_n(cpu_rd_n), .bsr_wr(bsr_wr), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
    .rd_data(b_data), .ibf(b_ibf), .intr(b_intr), .inte(b_inte),
    .pc_out(b_pco), .pc_oe(b_pcoe)
  );

  function automatic logic [2:0] own_bit(int ch);
    return (ch == 0) ? 3'd4 : 3'd2;
  endfunction

  function automatic logic [7:0] exp_pc(int ch, logic ibf_v, logic intr_v);
    logic [7:0] v;
    v = 8'h00;
    if (ch == 0) begin v[3] = intr_v; v[5] = ibf_v; end
    else         begin v[0] = intr_v; v[1] = ibf_v; end
    return v;
  endfunction

  function automatic logic [7:0] exp_oe(int ch);
    return (ch == 0) ? 8'h28 : 8'h03;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "A data", a_data, m_data);
    chk(req, "B data", b_data, m_data);
    chk(req, "A ibf", {7'd0, a_ibf}, {7'd0, m_ibf});
    chk(req, "B ibf", {7'd0, b_ibf}, {7'd0, m_ibf});
    chk(req, "A intr", {7'd0, a_intr}, {7'd0, m_intr[0]});
    chk(req, "B intr", {7'd0, b_intr}, {7'd0, m_intr[1]});
    chk(req, "A inte", {7'd0, a_inte}, {7'd0, m_inte[0]});
    chk(req, "B inte", {7'd0, b_inte}, {7'd0, m_inte[1]});
    chk("R8", "A pc_out", a_pco, exp_pc(0, m_ibf, m_intr[0]));
    chk("R8", "B pc_out", b_pco, exp_pc(1, m_ibf, m_intr[1]));
    chk("R8", "A pc_oe", a_pcoe, exp_oe(0));
    chk("R8", "B pc_oe", b_pcoe, exp_oe(1));
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe_lo(input logic [7:0] d);
    pin_data  = d;
    pin_stb_n = 1'b0;
    settle(5);
    m_data = d;
    m_ibf  = 1'b1;
  endtask

  task automatic strobe_hi();
    pin_stb_n = 1'b1;
    settle(5);
    for (int ch = 0; ch < 2; ch++) m_intr[ch] = m_inte[ch];
  endtask

  task automatic do_strobe(input logic [7:0] d);
    strobe_lo(d);
    check_all("R1 R2 strobe low");
    strobe_hi();
    check_all("R4 strobe released");
  endtask

  task automatic do_read();
    cpu_rd_n = 1'b0;
    settle(5);
    for (int ch = 0; ch < 2; ch++) m_intr[ch] = 1'b0;
    check_all("R5 read low");
    cpu_rd_n = 1'b1;
    settle(5);
    m_ibf = 1'b0;
    check_all("R3 read end");
  endtask

  task automatic do_bsr(input logic [2:0] b, input logic v);
    bsr_wr  = 1'b1;
    bsr_bit = b;
    bsr_val = v;
    @(negedge clk);
    bsr_wr = 1'b0;
    settle(3);
    for (int ch = 0; ch < 2; ch++) begin
      if (b == own_bit(ch)) begin
        m_inte[ch] = v;
        m_intr[ch] = v & m_ibf;
      end
    end
    check_all("R6 R7 set/reset");
  endtask

  initial begin
    void'($urandom(32'd5113));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    check_all("R11 reset");

    // R9: latency of three rising edges from pin to buffer-full
    pin_data  = 8'h5A;
    pin_stb_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "ibf after 2 edges", {7'd0, a_ibf}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "ibf after 3 edges", {7'd0, a_ibf}, 8'd1);
    settle(3);
    m_data = 8'h5A;
    m_ibf  = 1'b1;
    strobe_hi();
    check_all("R6 strobe with enable off");

    // R7: other bit indices ignored, own bit loads
    do_bsr(3'd3, 1'b1);
    do_bsr(3'd4, 1'b1);
    do_bsr(3'd2, 1'b1);
    do_bsr(3'd5, 1'b0);

    // R10: overwrite while full
    do_strobe(8'hC3);
    do_strobe(8'h3C);
    chk("R10", "overwritten byte", a_data, 8'h3C);

    // R3 clash: read end and new strobe in the same cycle
    cpu_rd_n = 1'b0;
    settle(5);
    for (int ch = 0; ch < 2; ch++) m_intr[ch] = 1'b0;
    check_all("R5 read low before clash");
    cpu_rd_n  = 1'b1;
    pin_data  = 8'hE7;
    pin_stb_n = 1'b0;
    settle(5);
    m_data = 8'hE7;
    m_ibf  = 1'b1;
    check_all("R3 strobe wins over read end");
    strobe_hi();
    check_all("R3 after clash release");
    do_read();

    // R6: disable while a request is pending
    do_strobe(8'h81);
    do_bsr(3'd4, 1'b0);
    do_bsr(3'd2, 1'b0);
    do_read();

    // Random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 6);
      if (op < 3)      do_strobe(8'($urandom()));
      else if (op < 5) do_read();
      else             do_bsr(3'($urandom_range(0, 7)), 1'($urandom()));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule